// File: doc/BRIEF.md
# Address Register Auto-Increment Unit

This unit keeps a bank of address registers and turns an operand request into an effective address. A request names one register, an addressing mode and an operand size. The unit then returns either the register contents unchanged, the contents with a post-step, or a pre-stepped address. For the two stepping modes it writes the stepped value back into the same register, so the surrounding datapath never has to do that arithmetic itself.

A separate write port loads registers. It can load a full-width value, or a 16-bit value that is sign-extended to the full width. The effective address appears registered, one clock after the request, and comes with a one-cycle valid pulse. Any register's current contents can be read through the normal path by issuing a plain-indirect request.

Top module: `addr_autoinc_unit`

## Requirements
- R1: After reset every register holds zero and `ea_valid_o` is low.
- R2: In plain-indirect mode (`mode_i` = 2'b00) the address returned equals the selected register, and that register keeps its value.
- R3: In post-increment mode (`mode_i` = 2'b01) the address returned is the register's old value, and the register then holds the old value plus the step.
- R4: In pre-decrement mode (`mode_i` = 2'b10) the register is first reduced by the step, and that reduced value is both the address returned and the new register contents.
- R5: The step follows `size_i`: 2'b00 (byte) gives 1, 2'b01 (word) gives 2, 2'b10 (long) gives 4, and 2'b11 is handled as long (4).
- R6: `mode_i` = 2'b11 behaves exactly like plain indirect: the address is the register value and no register changes.
- R7: Address arithmetic wraps modulo 2^32 both upward and downward.
- R8: With `wr_en_i` high the register `wr_sel_i` is loaded at the clock edge. With `wr_word_i` high, bits 15:0 of `wr_data_i` are sign-extended to 32 bits and the upper data bits are ignored; otherwise all 32 bits are stored.
- R9: If an external write and an auto-update target the same register in the same cycle, the external write value is stored. The request still returns the address formed from the old contents.
- R10: `ea_valid_o` is high in exactly the cycle after each cycle in which `req_i` is high, and low otherwise. `ea_o` is valid in that cycle.
- R11: Register 7 uses the same steps as the other registers, including a step of 1 for byte operands from an odd address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Operand address request strobe |
| reg_sel_i | input | 3 | Index of the register used by the request |
| mode_i | input | 2 | Addressing mode (00 indirect, 01 post-increment, 10 pre-decrement, 11 indirect) |
| size_i | input | 2 | Operand size (00 byte, 01 word, 10/11 long) |
| wr_en_i | input | 1 | Register load enable |
| wr_sel_i | input | 3 | Index of the register to load |
| wr_word_i | input | 1 | Load bits 15:0 sign-extended instead of the full word |
| wr_data_i | input | 32 | Load data |
| ea_o | output | 32 | Effective address, registered |
| ea_valid_o | output | 1 | One-cycle pulse marking `ea_o` valid |

## Verification
The bound checker enforces the valid-pulse timing on every cycle. It also checks every back-to-back pair of requests on one register: after an indirect or pre-decrement access the next indirect address is unchanged, after a post-increment it has advanced by the step, and a pre-decrement drops the address by its own step. The checker also confirms that a load followed by an indirect read returns the formatted load value. Several behaviours are shown only by the bench's directed scenarios: the reset contents of all eight registers, the wrap at both ends of the address space, the write-over-update collision, the treatment of size and mode code 11, and the byte step on register 7.

// File: rtl/aru_pkg.sv
package aru_pkg;

  typedef enum logic [1:0] {
    MODE_IND  = 2'b00,
    MODE_POST = 2'b01,
    MODE_PRE  = 2'b10,
    MODE_ALT  = 2'b11
  } aru_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_RSVD = 2'b11
  } aru_size_e;

  // Step in bytes for a given size code; the spare code acts as long.
  function automatic logic [2:0] size_step(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_step = 3'd1;
      SZ_WORD: size_step = 3'd2;
      default: size_step = 3'd4;
    endcase
  endfunction

  // Modes that read the register without touching it.
  function automatic logic mode_is_plain(input logic [1:0] md);
    mode_is_plain = (md == MODE_IND) || (md == MODE_ALT);
  endfunction

endpackage

// File: rtl/aru_load_fmt.sv
module aru_load_fmt #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic [ADDR_W-1:0] raw_i,
  input  logic              word_i,
  output logic [ADDR_W-1:0] val_o
);

  localparam int EXT_W = ADDR_W - WORD_W;

  always_comb begin
    if (word_i) begin
      val_o = {{EXT_W{raw_i[WORD_W-1]}}, raw_i[WORD_W-1:0]};
    end else begin
      val_o = raw_i;
    end
  end

endmodule

// File: rtl/aru_step_calc.sv
module aru_step_calc
  import aru_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        size_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              upd_o,
  output logic [ADDR_W-1:0] upd_val_o
);

  localparam int STEP_PAD = ADDR_W - 3;

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] base_up;
  logic [ADDR_W-1:0] base_dn;

  always_comb begin
    step    = {{STEP_PAD{1'b0}}, size_step(size_i)};
    base_up = base_i + step;
    base_dn = base_i - step;
  end

  always_comb begin
    ea_o      = base_i;
    upd_o     = 1'b0;
    upd_val_o = base_i;
    case (mode_i)
      MODE_POST: begin
        ea_o      = base_i;
        upd_o     = 1'b1;
        upd_val_o = base_up;
      end
      MODE_PRE: begin
        ea_o      = base_dn;
        upd_o     = 1'b1;
        upd_val_o = base_dn;
      end
      default: begin
        ea_o      = base_i;
        upd_o     = 1'b0;
        upd_val_o = base_i;
      end
    endcase
  end

endmodule

// File: rtl/aru_regbank.sv
module aru_regbank #(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int SEL_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [ADDR_W-1:0] rd_val_o,
  input  logic              upd_en_i,
  input  logic [SEL_W-1:0]  upd_sel_i,
  input  logic [ADDR_W-1:0] upd_val_i,
  input  logic              ld_en_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic [ADDR_W-1:0] ld_val_i
);

  logic [ADDR_W-1:0] bank_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic              ld_hit;
    logic              upd_hit;
    logic              en;
    logic [ADDR_W-1:0] nxt;

    always_comb begin
      ld_hit  = ld_en_i  && (ld_sel_i  == SEL_W'(g));
      upd_hit = upd_en_i && (upd_sel_i == SEL_W'(g));
      en      = ld_hit || upd_hit;
      // External load overrides an auto-update of the same entry.
      if (ld_hit) begin
        nxt = ld_val_i;
      end else begin
        nxt = upd_val_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (en) begin
        bank_q[g] <= nxt;
      end
    end
  end

  always_comb begin
    rd_val_o = bank_q[rd_sel_i];
  end

endmodule

// File: rtl/addr_autoinc_unit.sv
module addr_autoinc_unit #(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int WORD_W   = 16,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [SEL_W-1:0]  reg_sel_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        size_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic              wr_word_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              ea_valid_o
);

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] ea_d;
  logic              upd_raw;
  logic [ADDR_W-1:0] upd_val;
  logic [ADDR_W-1:0] ld_val;
  logic              upd_en;
  logic [ADDR_W-1:0] ea_q;
  logic              vld_q;
  logic [ADDR_W-1:0] ea_nxt;
  logic              vld_nxt;

  aru_load_fmt #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_fmt (
    .raw_i  (wr_data_i),
    .word_i (wr_word_i),
    .val_o  (ld_val)
  );

  aru_regbank #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_sel_i  (reg_sel_i),
    .rd_val_o  (base),
    .upd_en_i  (upd_en),
    .upd_sel_i (reg_sel_i),
    .upd_val_i (upd_val),
    .ld_en_i   (wr_en_i),
    .ld_sel_i  (wr_sel_i),
    .ld_val_i  (ld_val)
  );

  aru_step_calc #(.ADDR_W(ADDR_W)) u_calc (
    .base_i    (base),
    .mode_i    (mode_i),
    .size_i    (size_i),
    .ea_o      (ea_d),
    .upd_o     (upd_raw),
    .upd_val_o (upd_val)
  );

  always_comb begin
    upd_en  = req_i && upd_raw;
    vld_nxt = req_i;
    ea_nxt  = req_i ? ea_d : ea_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      ea_q  <= ea_nxt;
      vld_q <= vld_nxt;
    end
  end

  assign ea_o       = ea_q;
  assign ea_valid_o = vld_q;

endmodule

// File: rtl/aru_checker.sv
module aru_checker
  import aru_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int WORD_W   = 16,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_i,
  input logic [SEL_W-1:0]  reg_sel_i,
  input logic [1:0]        mode_i,
  input logic [1:0]        size_i,
  input logic              wr_en_i,
  input logic [SEL_W-1:0]  wr_sel_i,
  input logic              wr_word_i,
  input logic [ADDR_W-1:0] wr_data_i,
  input logic [ADDR_W-1:0] ea_o,
  input logic              ea_valid_o
);

  logic              p_req;
  logic [SEL_W-1:0]  p_sel;
  logic [1:0]        p_mode;
  logic [ADDR_W-1:0] p_step;
  logic              p_hit;
  logic              p_wr;
  logic [SEL_W-1:0]  p_wsel;
  logic [ADDR_W-1:0] p_wval;
  logic              chain;
  logic [ADDR_W-1:0] cur_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_req  <= 1'b0;
      p_sel  <= '0;
      p_mode <= '0;
      p_step <= '0;
      p_hit  <= 1'b0;
      p_wr   <= 1'b0;
      p_wsel <= '0;
      p_wval <= '0;
    end else begin
      p_req  <= req_i;
      p_sel  <= reg_sel_i;
      p_mode <= mode_i;
      p_step <= ADDR_W'(size_step(size_i));
      p_hit  <= wr_en_i && (wr_sel_i == reg_sel_i);
      p_wr   <= wr_en_i;
      p_wsel <= wr_sel_i;
      p_wval <= wr_word_i ? {{(ADDR_W-WORD_W){wr_data_i[WORD_W-1]}}, wr_data_i[WORD_W-1:0]}
                          : wr_data_i;
    end
  end

  always_comb begin
    chain    = req_i && p_req && (p_sel == reg_sel_i) && !p_hit && !(p_wr && p_wsel == reg_sel_i);
    cur_step = ADDR_W'(size_step(size_i));
  end

  assert_valid_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> ea_valid_o);

  assert_valid_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !ea_valid_o);

  // R2: indirect after indirect or pre-decrement sees the same register value.
  assert_indirect_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && mode_is_plain(mode_i) && p_mode != MODE_POST) |=> (ea_o == $past(ea_o)));

  assert_post_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && mode_is_plain(mode_i) && p_mode == MODE_POST) |=> (ea_o == $past(ea_o) + $past(p_step)));

  assert_pre_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && mode_i == MODE_PRE && p_mode != MODE_POST) |=> (ea_o == $past(ea_o) - $past(cur_step)));

  assert_load_then_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && mode_is_plain(mode_i) && p_wr && p_wsel == reg_sel_i) |=> (ea_o == $past(p_wval)));

endmodule

bind addr_autoinc_unit aru_checker u_chk (.*);

// File: tb/addr_autoinc_unit_tb.sv
module addr_autoinc_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        req_i;
  logic [2:0]  reg_sel_i;
  logic [1:0]  mode_i;
  logic [1:0]  size_i;
  logic        wr_en_i;
  logic [2:0]  wr_sel_i;
  logic        wr_word_i;
  logic [31:0] wr_data_i;
  logic [31:0] ea_o;
  logic        ea_valid_o;

  int n_chk;
  int n_fail;
  logic [31:0] mdl [8];
  logic [31:0] exp_q [$];
  string       tag_q [$];

  addr_autoinc_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .reg_sel_i  (reg_sel_i),
    .mode_i     (mode_i),
    .size_i     (size_i),
    .wr_en_i    (wr_en_i),
    .wr_sel_i   (wr_sel_i),
    .wr_word_i  (wr_word_i),
    .wr_data_i  (wr_data_i),
    .ea_o       (ea_o),
    .ea_valid_o (ea_valid_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] stp(input logic [1:0] sz);
    if (sz == 2'b00) return 32'd1;
    if (sz == 2'b01) return 32'd2;
    return 32'd4;
  endfunction

  // Expected address per the mode rules; updates the bench model.
  function automatic logic [31:0] predict(input int sel, input logic [1:0] md, input logic [1:0] sz);
    logic [31:0] old;
    old = mdl[sel];
    if (md == 2'b01) begin
      mdl[sel] = old + stp(sz);
      return old;
    end
    if (md == 2'b10) begin
      mdl[sel] = old - stp(sz);
      return mdl[sel];
    end
    return old;
  endfunction

  function automatic logic [31:0] fmt(input logic [31:0] d, input logic w);
    return w ? {{16{d[15]}}, d[15:0]} : d;
  endfunction

  task automatic do_req(input int sel, input logic [1:0] md, input logic [1:0] sz, input string tag);
    @(negedge clk);
    req_i     = 1'b1;
    reg_sel_i = 3'(sel);
    mode_i    = md;
    size_i    = sz;
    wr_en_i   = 1'b0;
    exp_q.push_back(predict(sel, md, sz));
    tag_q.push_back(tag);
  endtask

  task automatic do_wr(input int sel, input logic [31:0] d, input logic w);
    @(negedge clk);
    req_i     = 1'b0;
    wr_en_i   = 1'b1;
    wr_sel_i  = 3'(sel);
    wr_word_i = w;
    wr_data_i = d;
    mdl[sel]  = fmt(d, w);
  endtask

  task automatic do_both(input int rsel, input logic [1:0] md, input logic [1:0] sz,
                         input int wsel, input logic [31:0] d, input string tag);
    @(negedge clk);
    req_i     = 1'b1;
    reg_sel_i = 3'(rsel);
    mode_i    = md;
    size_i    = sz;
    wr_en_i   = 1'b1;
    wr_sel_i  = 3'(wsel);
    wr_word_i = 1'b0;
    wr_data_i = d;
    exp_q.push_back(predict(rsel, md, sz));
    tag_q.push_back(tag);
    mdl[wsel] = d;
  endtask

  task automatic quiet_check(input string tag);
    @(negedge clk);
    req_i   = 1'b0;
    wr_en_i = 1'b0;
    @(negedge clk);
    n_chk++;
    if (ea_valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL %s: ea_valid_o=%b expected 0", tag, ea_valid_o);
    end
  endtask

  // Monitor: pops one expected address per valid pulse.
  always @(negedge clk) begin
    if (rst_n && ea_valid_o === 1'b1) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10: unexpected valid, ea_o=%h expected no pulse", ea_o);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (ea_o !== e) begin
          n_fail++;
          $display("FAIL %s: ea_o=%h expected %h", t, ea_o, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0;
    n_fail = 0;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    rst_n = 1'b0;
    req_i = 1'b0;
    reg_sel_i = '0;
    mode_i = '0;
    size_i = '0;
    wr_en_i = 1'b0;
    wr_sel_i = '0;
    wr_word_i = 1'b0;
    wr_data_i = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (ea_valid_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: ea_valid_o=%b expected 0 in reset", ea_valid_o);
    end
    rst_n = 1'b1;

    // R1: all registers read back zero
    for (int i = 0; i < 8; i++) do_req(i, 2'b00, 2'b10, "R1 reset contents");
    quiet_check("R10 idle after burst");

    // R8 full load, R2 indirect leaves register
    do_wr(3, 32'h0000_1000, 1'b0);
    do_req(3, 2'b00, 2'b00, "R2 indirect first");
    do_req(3, 2'b00, 2'b10, "R2 indirect repeat");

    // R3/R5 post-increment at each size
    do_req(3, 2'b01, 2'b00, "R3 post byte");
    do_req(3, 2'b01, 2'b01, "R3 post word");
    do_req(3, 2'b01, 2'b10, "R3 post long");
    do_req(3, 2'b00, 2'b00, "R3 R5 after post");
    // R4/R5 pre-decrement at each size
    do_req(3, 2'b10, 2'b00, "R4 pre byte");
    do_req(3, 2'b10, 2'b01, "R4 pre word");
    do_req(3, 2'b10, 2'b10, "R4 pre long");
    do_req(3, 2'b00, 2'b00, "R4 R5 after pre");
    // R5 size code 11 as long
    do_req(3, 2'b01, 2'b11, "R5 size11 post");
    do_req(3, 2'b10, 2'b11, "R5 size11 pre");
    do_req(3, 2'b00, 2'b11, "R5 size11 readback");
    // R6 mode 11 is plain indirect
    do_req(3, 2'b11, 2'b10, "R6 mode11");
    do_req(3, 2'b11, 2'b00, "R6 mode11 again");
    do_req(3, 2'b00, 2'b10, "R6 unchanged");
    quiet_check("R10 idle");

    // R7 wrap both directions
    do_wr(1, 32'hFFFF_FFFE, 1'b0);
    do_req(1, 2'b01, 2'b10, "R7 post wrap");
    do_req(1, 2'b00, 2'b10, "R7 after up wrap");
    do_req(2, 2'b10, 2'b01, "R7 pre wrap from zero");
    do_req(2, 2'b00, 2'b01, "R7 after down wrap");

    // R8 word loads with sign extension and ignored upper bits
    do_wr(4, 32'h0000_FFF4, 1'b1);
    do_req(4, 2'b00, 2'b01, "R8 word negative");
    do_wr(4, 32'h1234_0004, 1'b1);
    do_req(4, 2'b00, 2'b01, "R8 word positive");
    do_wr(4, 32'hABCD_7FFF, 1'b1);
    do_req(4, 2'b00, 2'b01, "R8 word upper ignored");
    do_wr(4, 32'h8000_0001, 1'b0);
    do_req(4, 2'b00, 2'b01, "R8 full load");

    // R11 register 7 byte step from odd address
    do_wr(7, 32'h0000_2001, 1'b0);
    do_req(7, 2'b01, 2'b00, "R11 post byte");
    do_req(7, 2'b01, 2'b00, "R11 post byte again");
    do_req(7, 2'b10, 2'b00, "R11 pre byte");
    do_req(7, 2'b00, 2'b00, "R11 readback");

    // R9 collision: load wins, address from old value
    do_wr(5, 32'h0000_0100, 1'b0);
    do_both(5, 2'b01, 2'b10, 5, 32'h0000_5000, "R9 collision post");
    do_req(5, 2'b00, 2'b10, "R9 load kept");
    do_both(5, 2'b10, 2'b01, 5, 32'h0000_6000, "R9 collision pre");
    do_req(5, 2'b00, 2'b10, "R9 load kept pre");
    // R9 load to another register does not block the update
    do_both(5, 2'b01, 2'b10, 6, 32'h0000_0777, "R9 split targets");
    do_req(5, 2'b00, 2'b10, "R9 update applied");
    do_req(6, 2'b00, 2'b10, "R9 other load applied");
    quiet_check("R10 idle end");

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: %0d results missing, expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule